// File: doc/BRIEF.md
# Sampled-Core Cache Benefit Classifier

This block decides whether a workload spread over many identical cores gains anything from the shared last-level cache. Two cores are set aside as probes. One probe never allocates in the shared cache. The other probe inserts its fills at the most-recently-used position. The remaining cores follow whatever policy downstream logic chooses, and they play no part here. Each cycle the block receives the number of instructions that each probe retired in that cycle.

A window timer divides time into windows of a programmable number of cycles. Both probes are measured over the same window, so their retired-instruction totals can be compared directly as a throughput difference, with no division. When a window closes, the block forms the signed difference (cached probe minus bypassing probe) and compares it with an unsigned threshold. It then registers a cache-friendly flag, registers the inverse as a mask bit for a downstream way partitioner, and pulses a valid strobe. Both totals restart from zero in the next cycle.

Top module: `spc_ctrl`

## Requirements
- R1: While rst_ni is low and until the first window closes, friendly_o, mask_o and valid_o are all 0.
- R2: A window lasts W consecutive clock cycles, where W is win_len_i. The first window starts at the first rising edge after reset is released. valid_o is 1 in the cycle that follows the last edge of each window and is 0 in every other cycle.
- R3: A window total is the sum of the retire inputs sampled at every edge of that window, including its last edge. The next window starts from zero.
- R4: At the close of a window, friendly_o becomes 1 exactly when (cached total minus bypass total), taken as a signed value, is strictly greater than thresh_i, which is read as unsigned at the closing edge.
- R5: A difference exactly equal to thresh_i gives friendly_o = 0.
- R6: A negative difference, meaning the bypassing probe retired more, always gives friendly_o = 0, whatever the threshold.
- R7: After every decision, mask_o is the inverse of friendly_o. Mask 1 means the workload is not cache-friendly.
- R8: friendly_o and mask_o keep their values in every cycle in which no new decision is written.
- R9: A win_len_i of 0 behaves like a length of 1, so a decision is made on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_byp_i | input | RET_W | Instructions retired this cycle by the probe that bypasses the cache |
| ret_mru_i | input | RET_W | Instructions retired this cycle by the probe that inserts at MRU |
| thresh_i | input | CNT_W | Unsigned threshold on the instruction difference |
| win_len_i | input | WIN_W | Window length in cycles (0 behaves as 1) |
| friendly_o | output | 1 | Registered flag: caching helps this workload |
| mask_o | output | 1 | Registered mask bit for the partitioner, 1 when not cache-friendly |
| valid_o | output | 1 | One-cycle strobe when a new decision is written |

## Verification
The hardest cases to reach from the ports are a difference that lands exactly on the threshold, or exactly one above it. Random retire streams almost never produce these values. The bench therefore tracks the running totals itself and sets thresh_i during the last cycle of a window, to the exact difference or to one below it, because the threshold only matters at the closing edge. Windows where the bypassing probe is deliberately made faster, single-cycle windows, and windows with a length of zero complete the corner cases. Between those directed windows, the bench runs random windows with random lengths and random thresholds.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef struct packed {
    logic friendly;
    logic mask;
  } spc_dec_t;

  localparam spc_dec_t SPC_DEC_RST = '{friendly: 1'b0, mask: 1'b0};
endpackage

// File: rtl/spc_win_timer.sv
module spc_win_timer #(
  parameter int WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] len_i,
  output logic             end_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] lim;

  // zero length collapses to a single-cycle window
  assign lim   = (len_i == '0) ? '0 : len_i - 1'b1;
  assign end_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (end_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> (cnt_q == '0));
endmodule

// File: rtl/spc_ret_acc.sv
module spc_ret_acc #(
  parameter int RET_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] ret_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] acc_q;

  // total includes this cycle's retirements
  assign total_o = acc_q + CNT_W'(ret_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= total_o;
  end

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/spc_decide.sv
module spc_decide
  import spc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  logic [CNT_W-1:0] tot_mru_i,
  input  logic [CNT_W-1:0] tot_byp_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             friendly_o,
  output logic             mask_o,
  output logic             valid_o
);
  localparam int DW = CNT_W + 1;

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] thr_s;
  logic                 is_fr;
  spc_dec_t             dec_q;
  logic                 valid_q;

  assign diff  = $signed({1'b0, tot_mru_i}) - $signed({1'b0, tot_byp_i});
  assign thr_s = $signed({1'b0, thresh_i});
  assign is_fr = (diff > thr_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= SPC_DEC_RST;
      valid_q <= 1'b0;
    end else begin
      valid_q <= end_i;
      if (end_i) dec_q <= '{friendly: is_fr, mask: ~is_fr};
    end
  end

  assign friendly_o = dec_q.friendly;
  assign mask_o     = dec_q.mask;
  assign valid_o    = valid_q;

  a_r2_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> valid_o);
  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> !valid_o);
  a_r6_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && diff < 0) |=> !friendly_o);
  a_r7_mask_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mask_o == !friendly_o));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> ($stable(friendly_o) && $stable(mask_o)));
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl #(
  parameter int RET_W = 4,
  parameter int WIN_W = 12,
  parameter int CNT_W = WIN_W + RET_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] ret_byp_i,
  input  logic [RET_W-1:0] ret_mru_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             friendly_o,
  output logic             mask_o,
  output logic             valid_o
);
  localparam int NPROBE = 2;

  logic             win_end;
  logic [RET_W-1:0] ret_arr [NPROBE];
  logic [CNT_W-1:0] tot_arr [NPROBE];

  assign ret_arr[0] = ret_byp_i;
  assign ret_arr[1] = ret_mru_i;

  spc_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (win_len_i),
    .end_o  (win_end)
  );

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    spc_ret_acc #(.RET_W(RET_W), .CNT_W(CNT_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ret_i   (ret_arr[p]),
      .clr_i   (win_end),
      .total_o (tot_arr[p])
    );
  end

  spc_decide #(.CNT_W(CNT_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .end_i      (win_end),
    .tot_mru_i  (tot_arr[1]),
    .tot_byp_i  (tot_arr[0]),
    .thresh_i   (thresh_i),
    .friendly_o (friendly_o),
    .mask_o     (mask_o),
    .valid_o    (valid_o)
  );
endmodule

// File: tb/tb_spc_ctrl.sv
module tb_spc_ctrl;
  localparam int RET_W = 4;
  localparam int WIN_W = 12;
  localparam int CNT_W = WIN_W + RET_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [RET_W-1:0] ret_byp = '0;
  logic [RET_W-1:0] ret_mru = '0;
  logic [CNT_W-1:0] thresh = '0;
  logic [WIN_W-1:0] win_len = '0;
  logic             friendly, mask, valid;

  int checks = 0;
  int errors = 0;
  logic prev_fr = 1'b0;
  logic prev_mk = 1'b0;

  always #5 clk = ~clk;

  spc_ctrl #(.RET_W(RET_W), .WIN_W(WIN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ret_byp_i(ret_byp), .ret_mru_i(ret_mru),
    .thresh_i(thresh), .win_len_i(win_len),
    .friendly_o(friendly), .mask_o(mask), .valid_o(valid)
  );

  function automatic logic exp_friendly(longint m, longint b, longint t);
    return (m - b) > t;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: random; 1: thresh == diff; 2: thresh == diff-1; 3: bypass faster
  task automatic run_window(input int len_in, input int mode);
    int     len = (len_in == 0) ? 1 : len_in;
    longint sm = 0;
    longint sb = 0;
    logic   e;
    win_len = WIN_W'(len_in);
    if (mode == 0) thresh = CNT_W'($urandom_range(0, 4 * len));
    else if (mode == 3) thresh = '0;
    for (int c = 0; c < len; c++) begin
      case (mode)
        0: begin ret_mru = RET_W'($urandom_range(0, 15)); ret_byp = RET_W'($urandom_range(0, 15)); end
        3: begin ret_mru = RET_W'($urandom_range(0, 7));  ret_byp = RET_W'($urandom_range(8, 15)); end
        default: begin ret_mru = RET_W'($urandom_range(8, 15)); ret_byp = RET_W'($urandom_range(0, 7)); end
      endcase
      sm += ret_mru;
      sb += ret_byp;
      if (c == len - 1) begin
        if (mode == 1) thresh = CNT_W'(sm - sb);
        if (mode == 2) thresh = CNT_W'(sm - sb - 1);
      end
      @(negedge clk);
      if (c < len - 1) begin
        chk("R2 valid low mid-window", valid, 0);
        chk("R8 friendly held", friendly, prev_fr);
        chk("R8 mask held", mask, prev_mk);
      end
    end
    e = exp_friendly(sm, sb, longint'(thresh));
    chk("R2 valid after window", valid, 1);
    case (mode)
      1: chk("R5 equal diff not friendly", friendly, 0);
      2: chk("R4 diff above thresh friendly", friendly, 1);
      3: chk("R6 negative diff not friendly", friendly, 0);
      default: chk(len_in == 0 ? "R9 zero length" : "R3 R4 window decision", friendly, e);
    endcase
    chk("R7 mask inverse", mask, !e);
    prev_fr = e;
    prev_mk = !e;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    win_len = 12'd4;
    repeat (3) @(negedge clk);
    chk("R1 reset friendly", friendly, 0);
    chk("R1 reset mask", mask, 0);
    chk("R1 reset valid", valid, 0);
    rst_n = 1'b1;
    run_window(4, 0);
    run_window(8, 1);
    run_window(8, 2);
    run_window(6, 3);
    run_window(1, 2);
    run_window(1, 1);
    run_window(0, 2);
    run_window(0, 3);
    run_window(1, 0);
    run_window(2, 2);
    for (int i = 0; i < 150; i++) begin
      int md = (i % 5 == 4) ? int'($urandom_range(1, 3)) : 0;
      run_window(int'($urandom_range(1, 40)), md);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule